// File: doc/BRIEF.md
# CAST-128 Key Schedule Sequencer

This block expands a 128-bit cipher key into the 32-word round-key table used by the sixteen rounds of CAST-128. Each round has two words. One is a 32-bit masking key. The other is a 5-bit rotate amount, stored zero-extended to 32 bits. The expansion runs four passes over a pair of 128-bit working states, here called the primary state and the shadow state. Every pass first rebuilds the four shadow words from the primary words and then rebuilds the four primary words from the shadow words. The pass then derives eight table words from bytes of both states.

The four key-schedule substitution boxes are not held in the block. They are reached through four external synchronous lookup ports, one per box, so the surrounding design can store them in any memory that has one cycle of read latency. Each derived word needs five lookups, and each box takes only one lookup per cycle. A word is therefore built in three cycles: four lookups are issued, then the fifth, then the result is folded and written.

A one-cycle `start` launches a run. `busy` covers the run, and a one-cycle `done` marks its end. The finished table is read through an indexed combinational port and stays there until the next run overwrites it.

Top module: `cast_key_expander`

## Requirements
- R1: After reset, `busy` and `done` are low, all four lookup addresses are 0 and every table slot reads 0.
- R2: `key[127:120]` is key byte 0, the most significant byte of primary word 0, and `key[7:0]` is byte 15. Key bytes whose index is at or above `key_len` are replaced by zero when the run starts. A `key_len` of 16 or more keeps all sixteen bytes.
- R3: Each of four passes updates shadow words 0..3 and then primary words 0..3 in the CAST-128 order, and the state carries from one pass into the next. Box k (k = 0..3, the four key-schedule boxes in order) is read through `sbox_addr[k]`, and its data is taken from `sbox_data[k]` one cycle after the address. Byte 0 of a 32-bit word is bits 31:24 and byte 3 is bits 7:0.
- R4: Even slot 2r holds the 32-bit masking key of round r. Pass 0 writes rounds 0..7 and pass 1 writes rounds 8..15.
- R5: Odd slot 2r+1 holds the rotate amount of round r. It is the low 5 bits of the formula that produced slot 2r, evaluated in pass 2 (rounds 0..7) or pass 3 (rounds 8..15). Bits 31:5 of the slot are zero.
- R6: `done` rises on the 192nd rising edge after the edge that accepts `start`: 64 derived words at three cycles each.
- R7: `busy` is high from the accepting edge until the edge that raises `done`. `done` lasts exactly one cycle and is never high together with `busy`.
- R8: A `start` seen while `busy` is high is ignored. The run in progress keeps its key and its timing.
- R9: `rd_data` shows table slot `rd_idx` in the same cycle. The table keeps its contents while idle.
- R10: When a run completes, both working states are cleared. While idle, all four lookup addresses are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a key expansion (taken only when idle) |
| key | input | 128 | Cipher key, byte 0 in bits 127:120 |
| key_len | input | 5 | Key length in bytes; shorter keys are zero-padded |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | One-cycle completion pulse |
| sbox_addr | output | 32 | Four 8-bit lookup addresses, box k in bits 8k+7:8k |
| sbox_data | input | 128 | Four 32-bit lookup results, box k in bits 32k+31:32k |
| rd_idx | input | 5 | Table slot to read |
| rd_data | output | 32 | Content of the selected slot |

## Verification
The bench sweeps every key length from 0 to 17 and also an oversized length. A design that trims the wrong bytes or reverses the byte order gives a wrong table from the first slot onward. Each run compares all 32 slots against a schedule that the bench computes from the formulas. This exposes a single misplaced byte index, a wrong fifth box, a state word that fails to carry into the next pass, a rotate slot missing its mask, or a pass written to the wrong slot parity. A second `start` arriving mid-run must neither reload the key nor restart the count, which is visible as a changed table or a shifted `done`. After every run the lookup addresses must return to 0, which a design that keeps its working state would fail.

// File: rtl/cast_ks_pkg.sv
package cast_ks_pkg;
  localparam int WORD_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int KEY_BYTES = 16;
  localparam int KEY_W     = KEY_BYTES * BYTE_W;
  localparam int NBOX      = 4;
  localparam int ADDR_W    = BYTE_W;
  localparam int NUM_SLOTS = 32;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int ROT_W     = 5;
  localparam int LEN_W     = 5;
  localparam int SEL_W     = $clog2(KEY_BYTES) + 1;

  localparam logic [1:0] PH_MAIN  = 2'd0;
  localparam logic [1:0] PH_EXTRA = 2'd1;
  localparam logic [1:0] PH_FOLD  = 2'd2;

  // byte selector: top bit picks shadow (1) or primary (0), rest is byte number
  typedef logic [SEL_W-1:0] bsel_t;

  typedef struct packed {
    bsel_t [NBOX-1:0] a;     // one byte per box, box index = array index
    bsel_t            ax;    // fifth lookup
    logic  [1:0]      xbox;  // box used by the fifth lookup
  } look_t;

  typedef struct packed {
    look_t      lk;
    logic       base_z;
    logic [1:0] base_w;
    logic       dst_z;
    logic [1:0] dst_w;
  } mix_t;

  function automatic bsel_t px(int n);
    return {1'b0, 4'(n)};
  endfunction

  function automatic bsel_t sz(int n);
    return {1'b1, 4'(n)};
  endfunction

  function automatic look_t mk_look(bsel_t s0, bsel_t s1, bsel_t s2, bsel_t s3,
                                    bsel_t sx, logic [1:0] box);
    look_t l;
    l.a[0] = s0; l.a[1] = s1; l.a[2] = s2; l.a[3] = s3;
    l.ax   = sx; l.xbox = box;
    return l;
  endfunction

  // state-word update m (0..3 build shadow words, 4..7 build primary words)
  function automatic mix_t mix_spec(logic [2:0] m);
    mix_t r;
    logic [1:0] bx;
    bx = 2'(m + 3'd2);
    case (m)
      3'd0: begin r.lk = mk_look(px(13), px(15), px(12), px(14), px(8),  bx); r.base_z = 1'b0; r.base_w = 2'd0; end
      3'd1: begin r.lk = mk_look(sz(0),  sz(2),  sz(1),  sz(3),  px(10), bx); r.base_z = 1'b0; r.base_w = 2'd2; end
      3'd2: begin r.lk = mk_look(sz(7),  sz(6),  sz(5),  sz(4),  px(9),  bx); r.base_z = 1'b0; r.base_w = 2'd3; end
      3'd3: begin r.lk = mk_look(sz(10), sz(9),  sz(11), sz(8),  px(11), bx); r.base_z = 1'b0; r.base_w = 2'd1; end
      3'd4: begin r.lk = mk_look(sz(5),  sz(7),  sz(4),  sz(6),  sz(0),  bx); r.base_z = 1'b1; r.base_w = 2'd2; end
      3'd5: begin r.lk = mk_look(px(0),  px(2),  px(1),  px(3),  sz(2),  bx); r.base_z = 1'b1; r.base_w = 2'd0; end
      3'd6: begin r.lk = mk_look(px(7),  px(6),  px(5),  px(4),  sz(1),  bx); r.base_z = 1'b1; r.base_w = 2'd1; end
      default: begin r.lk = mk_look(px(10), px(9), px(11), px(8), sz(3), bx); r.base_z = 1'b1; r.base_w = 2'd3; end
    endcase
    r.dst_z = ~m[2];
    r.dst_w = m[1:0];
    return r;
  endfunction

  // table-word formula j of an even (odd = 0) or odd (odd = 1) pass
  function automatic look_t key_spec(logic odd, logic [2:0] j);
    look_t l;
    logic [1:0] bx;
    bx = j[1:0];
    case ({odd, j})
      4'h0: l = mk_look(sz(8),  sz(9),  sz(7),  sz(6),  sz(2),  bx);
      4'h1: l = mk_look(sz(10), sz(11), sz(5),  sz(4),  sz(6),  bx);
      4'h2: l = mk_look(sz(12), sz(13), sz(3),  sz(2),  sz(9),  bx);
      4'h3: l = mk_look(sz(14), sz(15), sz(1),  sz(0),  sz(12), bx);
      4'h4: l = mk_look(px(3),  px(2),  px(12), px(13), px(8),  bx);
      4'h5: l = mk_look(px(1),  px(0),  px(14), px(15), px(13), bx);
      4'h6: l = mk_look(px(7),  px(6),  px(8),  px(9),  px(3),  bx);
      4'h7: l = mk_look(px(5),  px(4),  px(10), px(11), px(7),  bx);
      4'h8: l = mk_look(sz(3),  sz(2),  sz(12), sz(13), sz(9),  bx);
      4'h9: l = mk_look(sz(1),  sz(0),  sz(14), sz(15), sz(12), bx);
      4'hA: l = mk_look(sz(7),  sz(6),  sz(8),  sz(9),  sz(2),  bx);
      4'hB: l = mk_look(sz(5),  sz(4),  sz(10), sz(11), sz(6),  bx);
      4'hC: l = mk_look(px(8),  px(9),  px(7),  px(6),  px(3),  bx);
      4'hD: l = mk_look(px(10), px(11), px(5),  px(4),  px(7),  bx);
      4'hE: l = mk_look(px(12), px(13), px(3),  px(2),  px(8),  bx);
      default: l = mk_look(px(14), px(15), px(1), px(0), px(13), bx);
    endcase
    return l;
  endfunction

  function automatic logic [BYTE_W-1:0] pick(logic [KEY_W-1:0] xs, logic [KEY_W-1:0] zs, bsel_t s);
    logic [KEY_W-1:0] v;
    v = s[SEL_W-1] ? zs : xs;
    return v[KEY_W-1-BYTE_W*int'(s[SEL_W-2:0]) -: BYTE_W];
  endfunction

  function automatic logic [WORD_W-1:0] get_word(logic [KEY_W-1:0] v, logic [1:0] w);
    return v[KEY_W-1-WORD_W*int'(w) -: WORD_W];
  endfunction

  function automatic logic [KEY_W-1:0] put_word(logic [KEY_W-1:0] v, logic [1:0] w,
                                                logic [WORD_W-1:0] d);
    logic [KEY_W-1:0] r;
    r = v;
    r[KEY_W-1-WORD_W*int'(w) -: WORD_W] = d;
    return r;
  endfunction

  function automatic logic [KEY_W-1:0] pad_key(logic [KEY_W-1:0] k, logic [LEN_W-1:0] len);
    logic [KEY_W-1:0] r;
    r = k;
    for (int i = 0; i < KEY_BYTES; i++)
      if (i >= int'(len)) r[KEY_W-1-BYTE_W*i -: BYTE_W] = '0;
    return r;
  endfunction

  // passes 0/1 fill even slots, 2/3 odd; odd passes cover the upper eight rounds
  function automatic logic [SLOT_W-1:0] slot_of(logic [1:0] pass, logic [2:0] j);
    return {pass[0], j, pass[1]};
  endfunction
endpackage

// File: rtl/cast_ks_seq.sv
module cast_ks_seq
  import cast_ks_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic [1:0] pass,
  output logic [3:0] item,
  output logic [1:0] phase,
  output logic       load,
  output logic       finish
);
  localparam logic [1:0] LAST_PASS = 2'd3;
  localparam logic [3:0] LAST_ITEM = 4'd15;

  assign load   = start && !busy;
  assign finish = busy && (phase == PH_FOLD) && (pass == LAST_PASS) && (item == LAST_ITEM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      pass  <= '0;
      item  <= '0;
      phase <= PH_MAIN;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy  <= 1'b1;
        pass  <= '0;
        item  <= '0;
        phase <= PH_MAIN;
      end else if (busy) begin
        if (phase == PH_FOLD) begin
          phase <= PH_MAIN;
          if (finish) begin
            busy <= 1'b0;
            done <= 1'b1;
            pass <= '0;
            item <= '0;
          end else begin
            {pass, item} <= {pass, item} + 6'd1;
          end
        end else begin
          phase <= phase + 2'd1;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy)); // R7
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != PH_FOLD) |=> (busy && phase == 2'($past(phase) + 2'd1)
                                    && {pass, item} == $past({pass, item}))); // R8
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == PH_FOLD && !finish) |=> (busy && phase == PH_MAIN
                                    && {pass, item} == 6'($past({pass, item}) + 6'd1))); // R6
endmodule

// File: rtl/cast_ks_mix.sv
module cast_ks_mix
  import cast_ks_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          busy,
  input  logic                          finish,
  input  logic [1:0]                    pass,
  input  logic [3:0]                    item,
  input  logic [1:0]                    phase,
  input  logic [KEY_W-1:0]              key_pad,
  input  logic [NBOX-1:0][WORD_W-1:0]   sb_data,
  output logic [NBOX-1:0][ADDR_W-1:0]   sb_addr,
  output logic                          wr_en,
  output logic [SLOT_W-1:0]             wr_slot,
  output logic [WORD_W-1:0]             wr_data,
  output logic                          state_zero
);
  logic [KEY_W-1:0]  xs, zs;
  logic [WORD_W-1:0] acc, res, base, sum4;
  logic              is_mix;
  mix_t              ms;
  look_t             lk;

  always_comb begin
    is_mix = ~item[3];
    ms     = mix_spec(item[2:0]);
    lk     = is_mix ? ms.lk : key_spec(pass[0], item[2:0]);
    base   = is_mix ? get_word(ms.base_z ? zs : xs, ms.base_w) : '0;
    sum4   = '0;
    for (int k = 0; k < NBOX; k++) sum4 = sum4 ^ sb_data[k];
    res    = acc ^ sb_data[lk.xbox];
  end

  for (genvar k = 0; k < NBOX; k++) begin : g_box
    assign sb_addr[k] = (phase == PH_EXTRA)
                        ? ((lk.xbox == 2'(k)) ? pick(xs, zs, lk.ax) : '0)
                        : pick(xs, zs, lk.a[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs  <= '0;
      zs  <= '0;
      acc <= '0;
    end else if (load) begin
      xs  <= key_pad;
      zs  <= '0;
      acc <= '0;
    end else if (busy) begin
      case (phase)
        PH_MAIN:  acc <= base;
        PH_EXTRA: acc <= acc ^ sum4;
        default: begin
          if (finish) begin
            xs <= '0;
            zs <= '0;
          end else if (is_mix) begin
            if (ms.dst_z) zs <= put_word(zs, ms.dst_w, res);
            else          xs <= put_word(xs, ms.dst_w, res);
          end
        end
      endcase
    end
  end

  assign wr_en      = busy && (phase == PH_FOLD) && !is_mix;
  assign wr_slot    = slot_of(pass, item[2:0]);
  assign wr_data    = pass[1] ? {{(WORD_W-ROT_W){1'b0}}, res[ROT_W-1:0]} : res;
  assign state_zero = (xs == '0) && (zs == '0);

  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sb_addr == '0)); // R10
  AST_WRITE_IN_KEY_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (busy && item[3])); // R4
endmodule

// File: rtl/cast_ks_bank.sv
module cast_ks_bank
  import cast_ks_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    mem[g] <= '0;
      else if (wr_en && wr_slot == SLOT_W'(g))       mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

  AST_ROTATE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot[0]) |-> (wr_data[WORD_W-1:ROT_W] == '0)); // R5
endmodule

// File: rtl/cast_key_expander.sv
module cast_key_expander
  import cast_ks_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [KEY_W-1:0]            key,
  input  logic [LEN_W-1:0]            key_len,
  output logic                        busy,
  output logic                        done,
  output logic [NBOX-1:0][ADDR_W-1:0] sbox_addr,
  input  logic [NBOX-1:0][WORD_W-1:0] sbox_data,
  input  logic [SLOT_W-1:0]           rd_idx,
  output logic [WORD_W-1:0]           rd_data
);
  logic [1:0]        pass, phase;
  logic [3:0]        item;
  logic              load, finish, wr_en, state_zero;
  logic [SLOT_W-1:0] wr_slot;
  logic [WORD_W-1:0] wr_data;
  logic [KEY_W-1:0]  key_pad;

  assign key_pad = pad_key(key, key_len);

  cast_ks_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass(pass), .item(item), .phase(phase), .load(load), .finish(finish)
  );

  cast_ks_mix u_mix (
    .clk(clk), .rst_n(rst_n), .load(load), .busy(busy), .finish(finish),
    .pass(pass), .item(item), .phase(phase), .key_pad(key_pad),
    .sb_data(sbox_data), .sb_addr(sbox_addr), .wr_en(wr_en),
    .wr_slot(wr_slot), .wr_data(wr_data), .state_zero(state_zero)
  );

  cast_ks_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  AST_STATE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> state_zero); // R10
endmodule

// File: tb/cast_key_expander_bench.sv
module cast_key_expander_bench;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [127:0]       key = '0;
  logic [4:0]         key_len = '0;
  logic [4:0]         rd_idx = '0;
  logic               busy, done;
  logic [3:0][7:0]    sbox_addr;
  logic [3:0][31:0]   sbox_data = '0;
  logic [31:0]        rd_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_total = 0;
  logic [31:0] exp_ks [32];

  always #10 clk = ~clk; // 50 MHz

  cast_key_expander u_cast_key_expander (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .key_len(key_len),
    .busy(busy), .done(done), .sbox_addr(sbox_addr), .sbox_data(sbox_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // arbitrary fixed box contents
  function automatic logic [31:0] sbf(int b, logic [7:0] a);
    logic [31:0] t;
    t = {a, a ^ 8'h5A, ~a, a + 8'(b * 37 + 11)};
    t = t * 32'h2545F491 + 32'(b + 1) * 32'h9E3779B9;
    return t ^ (t >> 13) ^ (t << 7);
  endfunction

  // one-cycle read latency model of the four boxes
  always @(posedge clk)
    for (int k = 0; k < 4; k++) sbox_data[k] <= sbf(k, sbox_addr[k]);

  function automatic logic [7:0] bx(logic [127:0] v, int n);
    return v[127 - 8*n -: 8];
  endfunction

  function automatic logic [31:0] s(int b, logic [7:0] a);
    return sbf(b, a);
  endfunction

  function automatic logic [31:0] g(logic [127:0] v, int a, int b, int c, int d);
    return s(0, bx(v, a)) ^ s(1, bx(v, b)) ^ s(2, bx(v, c)) ^ s(3, bx(v, d));
  endfunction

  function automatic logic [127:0] bpad(logic [127:0] k, int len);
    int eff;
    eff = (len > 16) ? 16 : len;
    if (eff < 16) k = k & ~((128'h1 << (128 - 8*eff)) - 128'h1);
    return k;
  endfunction

  task automatic golden(input logic [127:0] kin);
    logic [127:0] X, Z;
    logic [31:0] t [8];
    X = kin; Z = '0;
    for (int p = 0; p < 4; p++) begin
      Z[127:96] = X[127:96] ^ g(X, 13, 15, 12, 14) ^ s(2, bx(X, 8));
      Z[95:64]  = X[63:32]  ^ g(Z, 0, 2, 1, 3)     ^ s(3, bx(X, 10));
      Z[63:32]  = X[31:0]   ^ g(Z, 7, 6, 5, 4)     ^ s(0, bx(X, 9));
      Z[31:0]   = X[95:64]  ^ g(Z, 10, 9, 11, 8)   ^ s(1, bx(X, 11));
      X[127:96] = Z[63:32]  ^ g(Z, 5, 7, 4, 6)     ^ s(2, bx(Z, 0));
      X[95:64]  = Z[127:96] ^ g(X, 0, 2, 1, 3)     ^ s(3, bx(Z, 2));
      X[63:32]  = Z[95:64]  ^ g(X, 7, 6, 5, 4)     ^ s(0, bx(Z, 1));
      X[31:0]   = Z[31:0]   ^ g(X, 10, 9, 11, 8)   ^ s(1, bx(Z, 3));
      if (p % 2 == 0) begin
        t[0] = g(Z, 8, 9, 7, 6)    ^ s(0, bx(Z, 2));
        t[1] = g(Z, 10, 11, 5, 4)  ^ s(1, bx(Z, 6));
        t[2] = g(Z, 12, 13, 3, 2)  ^ s(2, bx(Z, 9));
        t[3] = g(Z, 14, 15, 1, 0)  ^ s(3, bx(Z, 12));
        t[4] = g(X, 3, 2, 12, 13)  ^ s(0, bx(X, 8));
        t[5] = g(X, 1, 0, 14, 15)  ^ s(1, bx(X, 13));
        t[6] = g(X, 7, 6, 8, 9)    ^ s(2, bx(X, 3));
        t[7] = g(X, 5, 4, 10, 11)  ^ s(3, bx(X, 7));
      end else begin
        t[0] = g(Z, 3, 2, 12, 13)  ^ s(0, bx(Z, 9));
        t[1] = g(Z, 1, 0, 14, 15)  ^ s(1, bx(Z, 12));
        t[2] = g(Z, 7, 6, 8, 9)    ^ s(2, bx(Z, 2));
        t[3] = g(Z, 5, 4, 10, 11)  ^ s(3, bx(Z, 6));
        t[4] = g(X, 8, 9, 7, 6)    ^ s(0, bx(X, 3));
        t[5] = g(X, 10, 11, 5, 4)  ^ s(1, bx(X, 7));
        t[6] = g(X, 12, 13, 3, 2)  ^ s(2, bx(X, 8));
        t[7] = g(X, 14, 15, 1, 0)  ^ s(3, bx(X, 13));
      end
      for (int j = 0; j < 8; j++) begin
        int r;
        r = (p % 2) * 8 + j;
        if (p < 2) exp_ks[2*r]     = t[j];
        else       exp_ks[2*r + 1] = t[j] & 32'h1F;
      end
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, expv);
    end
  endtask

  task automatic read_table(input string extra);
    for (int sl = 0; sl < 32; sl++) begin
      @(negedge clk);
      rd_idx = 5'(sl);
      #2;
      if (sl % 2 == 0)
        chk(rd_data === exp_ks[sl], $sformatf("R3 R4 R9 %s mask slot %0d", extra, sl), rd_data, exp_ks[sl]);
      else
        chk(rd_data === exp_ks[sl], $sformatf("R3 R5 R9 %s rotate slot %0d", extra, sl), rd_data, exp_ks[sl]);
    end
  endtask

  // poke_at > 0 drives a second start with k_alt that many cycles into the run
  task automatic run_sched(input logic [127:0] k, input logic [4:0] len, input int poke_at,
                           input logic [127:0] k_alt, input string extra);
    int n;
    bit seen, busy_bad;
    golden(bpad(k, int'(len)));
    @(negedge clk);
    key = k; key_len = len; start = 1'b1;
    n = 0; seen = 0; busy_bad = 0;
    while (!seen && n < 400) begin
      @(negedge clk);
      n++;
      start = (n == poke_at);
      if (n == poke_at) begin key = k_alt; key_len = 5'd16; end
      if (done) seen = 1;
      else if (busy !== 1'b1) busy_bad = 1;
    end
    start = 1'b0;
    // done visible at the negedge following the 192nd edge after acceptance
    chk(n == 193, $sformatf("R6 %s done timing (cycles)", extra), 32'(n), 32'd193);
    chk(!busy_bad, $sformatf("R7 %s busy held during run", extra), {31'd0, busy_bad}, 32'd0);
    chk(busy === 1'b0, $sformatf("R7 %s busy low with done", extra), {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(done === 1'b0, $sformatf("R7 %s done one cycle", extra), {31'd0, done}, 32'd0);
    chk(sbox_addr === '0, $sformatf("R10 %s idle addresses cleared", extra), sbox_addr, 32'd0);
    read_table(extra);
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cyc_total);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [127:0] k1, k2, k3;
    k1 = 128'h0123456712345678234567893456789A;
    k2 = {128{1'b1}};
    k3 = 128'hF00DCAFE_8badF00d_13579BDF_02468ACE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0, "R1 busy after reset", {31'd0, busy}, 32'd0);
    chk(done === 1'b0, "R1 done after reset", {31'd0, done}, 32'd0);
    chk(sbox_addr === '0, "R1 addresses after reset", sbox_addr, 32'd0);
    for (int sl = 0; sl < 32; sl++) begin
      rd_idx = 5'(sl);
      #1;
      chk(rd_data === 32'd0, $sformatf("R1 slot %0d after reset", sl), rd_data, 32'd0);
    end

    // full-length keys of different patterns
    run_sched(k1, 5'd16, 0, '0, "full k1");
    run_sched(k2, 5'd16, 0, '0, "full k2");
    run_sched(k3, 5'd16, 0, '0, "full k3");
    run_sched('0, 5'd16, 0, '0, "full zero");

    // R2: every length, including lengths above 16
    for (int L = 0; L <= 17; L++)
      run_sched(k3, 5'(L), 0, '0, $sformatf("R2 len %0d", L));
    run_sched(k1, 5'd31, 0, '0, "R2 len 31");

    // R8: start during a run is ignored
    run_sched(k1, 5'd10, 60, k2, "R8 restart ignored");

    // R9: table retained while idle
    repeat (25) @(negedge clk);
    read_table("R9 retained");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule